// File: doc/BRIEF.md
# Keyed Configuration Register Target

This block is the configuration side of a multi-function I/O controller, seen through a two-byte port window on a byte-wide host bus. A write at offset 0 loads a register index. A read or write at offset 1 reaches the register that index names. A read at offset 0 returns the current index. The whole configuration space stays hidden until the host writes an unlock key to the index port. Two key styles are available through a parameter. The pair style uses two bytes and is left with a single byte at the index port. The quad style uses four bytes, and its last byte depends on the base port the controller is strapped to. Quad-style configuration mode is left by a command written to a configuration register.

Indices below 0x30 form a global register file. It holds a device-select register, a read-only chip identifier and general scratch bytes. Indices from 0x30 upward are banked per logical device, and the device-select register picks the active bank. Each bank holds an enable byte, a primary and a secondary I/O base (high byte first), an interrupt number and a DMA channel.

Top module: `cfg_port_target`

## Requirements
- R1: After reset the block is locked. Reads at either offset return 0xFF, and once unlocked the device-select register (index 0x07) reads 0x00.
- R2: While locked, reads at either offset return 0xFF. Data-port writes change no register, and index-port writes do not load the index.
- R3: Pair style: two consecutive 0x87 writes to the index port unlock the block. Writing 0xAA to the index port while unlocked locks it again.
- R4: Quad style: the index-port writes 0x87, 0x01, 0x55 and then a final byte unlock the block. The final byte is 0x55 when BASE_PORT is 0x2E and 0xAA for any other base port. Any other final byte leaves the block locked.
- R5: Quad style: writing 0x02 to register 0x02 locks the block. In this style, 0xAA written to the index port only loads the index.
- R6: A mismatching key byte returns the key matcher to idle. A 0x87 that breaks a sequence counts as the first key byte.
- R7: Read data appears on rdata_o one clock after the rd_i cycle and holds until the next read. Offset 0 returns the index, and offset 1 returns the indexed register.
- R8: Registers 0x20 and 0x21 return CHIP_ID_HI and CHIP_ID_LO, and writes to them are ignored.
- R9: Register 0x07 selects the logical device. Banked registers 0x30, 0x60 to 0x63, 0x70 and 0x74 are stored separately per device. After reset they read 0x00, except 0x74, which reads 0x04.
- R10: With a selected device number of NUM_LDEV or above, banked reads return 0xFF and banked writes are ignored.
- R11: Unimplemented banked indices read 0x00. Other global indices are read/write scratch bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 1 | Window offset: 0 index port, 1 data port |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
The assertions check on every cycle that a locked read yields 0xFF and that rdata_o moves only after a read. They also check that unlocking happens only on an index write carrying the final key byte, and that each exit mechanism locks the block on the next cycle. Further cycle checks cover out-of-range device reads returning 0xFF and the identifier high byte reading back correctly. Only the bench scenarios can show the following: that banks are kept separate, that scratch contents survive a lock and unlock cycle, that a 0x87 restarts a broken key, and that the base-port-dependent final byte is the one the matcher accepts.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic {KEY_PAIR = 1'b0, KEY_QUAD = 1'b1} key_style_e;

  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] BANK_START  = 8'h30;
  localparam logic [7:0] KEY_LEAD    = 8'h87;
  localparam logic [7:0] PAIR_LEAVE  = 8'hAA;
  localparam logic [7:0] QUAD_LEAVE  = 8'h02;
  localparam int unsigned BANK_SLOTS = 7;
  localparam logic [2:0] SLOT_MISS   = 3'd7;

  function automatic int unsigned key_len(input key_style_e s);
    return (s == KEY_PAIR) ? 2 : 4;
  endfunction

  function automatic logic [7:0] key_byte(input key_style_e s, input logic [15:0] base,
                                          input int unsigned pos);
    if (s == KEY_PAIR) return KEY_LEAD;
    case (pos)
      0:       return KEY_LEAD;
      1:       return 8'h01;
      2:       return 8'h55;
      default: return (base == 16'h002E) ? 8'h55 : 8'hAA;
    endcase
  endfunction

  // Map a banked index onto a storage slot; SLOT_MISS for unimplemented.
  function automatic logic [2:0] bank_slot(input logic [7:0] idx);
    case (idx)
      8'h30:   return 3'd0;
      8'h60:   return 3'd1;
      8'h61:   return 3'd2;
      8'h62:   return 3'd3;
      8'h63:   return 3'd4;
      8'h70:   return 3'd5;
      8'h74:   return 3'd6;
      default: return SLOT_MISS;
    endcase
  endfunction

  function automatic logic [7:0] slot_reset(input int unsigned slot);
    return (slot == 6) ? 8'h04 : 8'h00;
  endfunction

endpackage

// File: rtl/cfg_key_matcher.sv
module cfg_key_matcher
  import cfg_port_pkg::*;
#(
  parameter key_style_e  KEY_STYLE = KEY_PAIR,
  parameter logic [15:0] BASE_PORT = 16'h002E
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_byte_i,
  input  logic       lock_req_i,
  output logic       open_o
);
  localparam int unsigned KLEN = key_len(KEY_STYLE);

  logic [1:0] stage_q;
  logic       open_q;
  logic       hit;

  assign hit    = (key_byte_i == key_byte(KEY_STYLE, BASE_PORT, int'(stage_q)));
  assign open_o = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      stage_q <= '0;
    end else if (lock_req_i) begin
      open_q  <= 1'b0;
      stage_q <= '0;
    end else if (key_we_i && !open_q) begin
      if (hit) begin
        if (int'(stage_q) == KLEN - 1) begin
          open_q  <= 1'b1;
          stage_q <= '0;
        end else begin
          stage_q <= stage_q + 2'd1;
        end
      end else begin
        stage_q <= (key_byte_i == KEY_LEAD) ? 2'd1 : 2'd0;
      end
    end
  end
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter key_style_e KEY_STYLE  = KEY_PAIR,
  parameter logic [7:0] CHIP_ID_HI = 8'hC5,
  parameter logic [7:0] CHIP_ID_LO = 8'h11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] ldn_o,
  output logic       exit_o
);
  localparam int unsigned AW    = $clog2(int'(BANK_START));
  localparam int unsigned DEPTH = 2 ** AW;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] ldn_q;
  logic       is_exit_idx;
  logic       special;

  assign is_exit_idx = (KEY_STYLE == KEY_QUAD) && (idx_i == IDX_EXIT);
  assign special     = (idx_i == IDX_LDN) || (idx_i == IDX_ID_HI) ||
                       (idx_i == IDX_ID_LO) || is_exit_idx;
  assign exit_o      = we_i && is_exit_idx && (wdata_i == QUAD_LEAVE);
  assign ldn_o       = ldn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      if (idx_i == IDX_LDN) ldn_q <= wdata_i;
      else if (!special)    mem_q[idx_i[AW-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    if (idx_i == IDX_LDN)        rdata_o = ldn_q;
    else if (idx_i == IDX_ID_HI) rdata_o = CHIP_ID_HI;
    else if (idx_i == IDX_ID_LO) rdata_o = CHIP_ID_LO;
    else if (is_exit_idx)        rdata_o = 8'h00;
    else                         rdata_o = mem_q[idx_i[AW-1:0]];
  end
endmodule

// File: rtl/cfg_ldev_bank.sv
module cfg_ldev_bank
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_LDEV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] ldn_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  localparam int unsigned CELLS = NUM_LDEV * BANK_SLOTS;

  logic [7:0] cell_w [CELLS];
  logic [2:0] slot;
  logic       in_range;

  assign slot     = bank_slot(idx_i);
  assign in_range = (32'(ldn_i) < NUM_LDEV);

  for (genvar d = 0; d < int'(NUM_LDEV); d++) begin : g_dev
    for (genvar s = 0; s < int'(BANK_SLOTS); s++) begin : g_slot
      logic [7:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= slot_reset(s);
        else if (we_i && (32'(ldn_i) == d) && (32'(slot) == s)) r_q <= wdata_i;
      end
      assign cell_w[d*BANK_SLOTS+s] = r_q;
    end
  end

  always_comb begin
    if (!in_range)              rdata_o = 8'hFF;
    else if (slot == SLOT_MISS) rdata_o = 8'h00;
    else                        rdata_o = cell_w[32'(ldn_i) * BANK_SLOTS + 32'(slot)];
  end
endmodule

// File: rtl/cfg_port_target.sv
module cfg_port_target
  import cfg_port_pkg::*;
#(
  parameter key_style_e  KEY_STYLE  = KEY_PAIR,
  parameter logic [15:0] BASE_PORT  = 16'h002E,
  parameter int unsigned NUM_LDEV   = 4,
  parameter logic [7:0]  CHIP_ID_HI = 8'hC5,
  parameter logic [7:0]  CHIP_ID_LO = 8'h11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic       key_open;
  logic [7:0] idx_q;
  logic [7:0] ldn_sel;
  logic [7:0] glb_rdata;
  logic [7:0] bank_rdata;
  logic [7:0] rdata_q;
  logic       glb_exit;
  logic       idx_wr, data_wr, pair_leave, is_global;

  assign idx_wr     = wr_i && !addr_i;
  assign data_wr    = wr_i && addr_i && key_open;
  assign pair_leave = (KEY_STYLE == KEY_PAIR) && key_open && idx_wr && (wdata_i == PAIR_LEAVE);
  assign is_global  = (idx_q < BANK_START);

  cfg_key_matcher #(.KEY_STYLE(KEY_STYLE), .BASE_PORT(BASE_PORT)) u_key (
    .clk_i, .rst_ni,
    .key_we_i  (idx_wr && !key_open),
    .key_byte_i(wdata_i),
    .lock_req_i(pair_leave || glb_exit),
    .open_o    (key_open)
  );

  cfg_global_regs #(.KEY_STYLE(KEY_STYLE), .CHIP_ID_HI(CHIP_ID_HI), .CHIP_ID_LO(CHIP_ID_LO)) u_glb (
    .clk_i, .rst_ni,
    .we_i   (data_wr && is_global),
    .idx_i  (idx_q),
    .wdata_i,
    .rdata_o(glb_rdata),
    .ldn_o  (ldn_sel),
    .exit_o (glb_exit)
  );

  cfg_ldev_bank #(.NUM_LDEV(NUM_LDEV)) u_bank (
    .clk_i, .rst_ni,
    .we_i   (data_wr && !is_global),
    .idx_i  (idx_q),
    .ldn_i  (ldn_sel),
    .wdata_i,
    .rdata_o(bank_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      rdata_q <= 8'hFF;
    end else begin
      if (idx_wr && key_open && !pair_leave) idx_q <= wdata_i;
      if (rd_i) begin
        if (!key_open)    rdata_q <= 8'hFF;
        else if (!addr_i) rdata_q <= idx_q;
        else              rdata_q <= is_global ? glb_rdata : bank_rdata;
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cfg_port_target_chk.sv
module cfg_port_target_chk
  import cfg_port_pkg::*;
#(
  parameter key_style_e  KEY_STYLE  = KEY_PAIR,
  parameter logic [15:0] BASE_PORT  = 16'h002E,
  parameter int unsigned NUM_LDEV   = 4,
  parameter logic [7:0]  CHIP_ID_HI = 8'hC5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       open_i,
  input logic [7:0] idx_i,
  input logic [7:0] ldn_i
);
  localparam logic [7:0] FINAL_KEY = key_byte(KEY_STYLE, BASE_PORT, key_len(KEY_STYLE) - 1);

  p_locked_read_ff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_i && rd_i) |=> (rdata_o == 8'hFF));

  p_unlock_on_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_i) |-> ($past(wr_i && !addr_i) && ($past(wdata_i) == FINAL_KEY)));

  p_pair_leave_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((KEY_STYLE == KEY_PAIR) && open_i && wr_i && !addr_i && (wdata_i == 8'hAA)) |=> !open_i);

  p_quad_leave_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((KEY_STYLE == KEY_QUAD) && open_i && wr_i && addr_i && (idx_i == 8'h02) && (wdata_i == 8'h02))
      |=> !open_i);

  p_ldn_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && rd_i && addr_i && (idx_i >= 8'h30) && (32'(ldn_i) >= NUM_LDEV)) |=> (rdata_o == 8'hFF));

  p_id_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && rd_i && addr_i && (idx_i == 8'h20)) |=> (rdata_o == CHIP_ID_HI));

  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind cfg_port_target cfg_port_target_chk #(
  .KEY_STYLE(KEY_STYLE), .BASE_PORT(BASE_PORT), .NUM_LDEV(NUM_LDEV), .CHIP_ID_HI(CHIP_ID_HI)
) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
  .open_i(key_open), .idx_i(idx_q), .ldn_i(ldn_sel)
);

// File: tb/test_cfg_port_target.sv
module test_cfg_port_target;
  import cfg_port_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, rd = 1'b0, wr_a = 1'b0, wr_b = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_a, rdata_b;
  int         checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_target #(.KEY_STYLE(KEY_PAIR), .BASE_PORT(16'h002E), .NUM_LDEV(4),
                    .CHIP_ID_HI(8'hC5), .CHIP_ID_LO(8'h11)) i_cfg_port_target (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_a), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata_a));

  cfg_port_target #(.KEY_STYLE(KEY_QUAD), .BASE_PORT(16'h004E), .NUM_LDEV(4),
                    .CHIP_ID_HI(8'hD4), .CHIP_ID_LO(8'h2A)) i_cfg_port_target_quad (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_b), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata_b));

  // {req, check, addr, wr, rd, data, expected}
  function automatic logic [23:0] v(input int req, input bit chk, input bit a, input bit w,
                                    input bit r, input logic [7:0] d, input logic [7:0] e);
    return {4'(req), chk, a, w, r, d, e};
  endfunction

  localparam int NV = 48;
  localparam logic [23:0] VEC [NV] = '{
    v(2,1,1,0,1,8'h00,8'hFF),                                                     // R2 locked
    v(3,0,0,1,0,8'h87,8'h00), v(3,0,0,1,0,8'h87,8'h00),                           // R3 key
    v(8,0,0,1,0,8'h20,8'h00), v(8,1,1,0,1,8'h00,8'hC5),                           // R8 id hi
    v(8,0,0,1,0,8'h21,8'h00), v(8,1,1,0,1,8'h00,8'h11),                           // R8 id lo
    v(1,0,0,1,0,8'h07,8'h00), v(1,1,1,0,1,8'h00,8'h00),                           // R1 ldn 0
    v(9,0,1,1,0,8'h02,8'h00), v(9,0,0,1,0,8'h60,8'h00), v(9,0,1,1,0,8'h3A,8'h00),
    v(9,1,1,0,1,8'h00,8'h3A),                                                     // R9 write dev2
    v(9,0,0,1,0,8'h07,8'h00), v(9,0,1,1,0,8'h01,8'h00), v(9,0,0,1,0,8'h60,8'h00),
    v(9,1,1,0,1,8'h00,8'h00),                                                     // R9 dev1 separate
    v(9,0,0,1,0,8'h74,8'h00), v(9,1,1,0,1,8'h00,8'h04),                           // R9 dma reset
    v(10,0,0,1,0,8'h07,8'h00), v(10,0,1,1,0,8'h06,8'h00), v(10,0,0,1,0,8'h60,8'h00),
    v(10,0,1,1,0,8'h55,8'h00), v(10,1,1,0,1,8'h00,8'hFF),                         // R10 out of range
    v(10,0,0,1,0,8'h07,8'h00), v(10,0,1,1,0,8'h02,8'h00), v(10,0,0,1,0,8'h60,8'h00),
    v(10,1,1,0,1,8'h00,8'h3A),                                                    // R10 write ignored
    v(8,0,0,1,0,8'h20,8'h00), v(8,0,1,1,0,8'h00,8'h00), v(8,1,1,0,1,8'h00,8'hC5), // R8 read-only
    v(11,0,0,1,0,8'h25,8'h00), v(11,0,1,1,0,8'h9C,8'h00), v(11,1,1,0,1,8'h00,8'h9C), // R11 scratch
    v(11,0,0,1,0,8'h41,8'h00), v(11,1,1,0,1,8'h00,8'h00),                         // R11 unimplemented
    v(7,1,0,0,1,8'h00,8'h41),                                                     // R7 index read
    v(3,0,0,1,0,8'h25,8'h00), v(3,0,0,1,0,8'hAA,8'h00), v(3,1,1,0,1,8'h00,8'hFF), // R3 leave
    v(2,0,1,1,0,8'h12,8'h00), v(2,1,0,0,1,8'h00,8'hFF),                           // R2 locked write
    v(6,0,0,1,0,8'h87,8'h00), v(6,0,0,1,0,8'h11,8'h00), v(6,0,0,1,0,8'h87,8'h00),
    v(6,1,1,0,1,8'h00,8'hFF),                                                     // R6 broken key
    v(6,0,0,1,0,8'h87,8'h00), v(2,1,1,0,1,8'h00,8'h9C)                            // R6 restart, R2 kept
  };

  task automatic cyc(input bit sel_b, input bit a, input bit w, input bit r, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd = r; wdata = d;
    wr_a = w && !sel_b;
    wr_b = w && sel_b;
    @(posedge clk);
    #1;
    wr_a = 1'b0; wr_b = 1'b0; rd = 1'b0;
  endtask

  task automatic check(input bit sel_b, input string req, input logic [7:0] exp);
    logic [7:0] act;
    @(negedge clk);
    act = sel_b ? rdata_b : rdata_a;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input bit sel_b, input bit a, input string req, input logic [7:0] exp);
    cyc(sel_b, a, 1'b0, 1'b1, 8'h00);
    check(sel_b, req, exp);
  endtask

  task automatic key_b(input logic [7:0] k0, input logic [7:0] k1, input logic [7:0] k2,
                       input logic [7:0] k3);
    cyc(1, 0, 1, 0, k0); cyc(1, 0, 1, 0, k1); cyc(1, 0, 1, 0, k2); cyc(1, 0, 1, 0, k3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(0, 0, "R1", 8'hFF);
    rd_chk(1, 1, "R1", 8'hFF);

    for (int i = 0; i < NV; i++) begin
      cyc(0, VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
      if (VEC[i][19]) check(0, $sformatf("R%0d vec%0d", VEC[i][23:20], i), VEC[i][7:0]);
    end

    // R4: wrong final byte for base 0x4E
    key_b(8'h87, 8'h01, 8'h55, 8'h55);
    rd_chk(1, 1, "R4 wrong final", 8'hFF);
    key_b(8'h87, 8'h01, 8'h55, 8'hAA);
    cyc(1, 0, 1, 0, 8'h20);
    rd_chk(1, 1, "R4 unlocked id", 8'hD4);
    // R5: 0xAA at index port only loads the index in quad style
    cyc(1, 0, 1, 0, 8'hAA);
    rd_chk(1, 1, "R5 no leave", 8'h00);
    rd_chk(1, 0, "R7 index", 8'hAA);
    cyc(1, 0, 1, 0, 8'h02);
    cyc(1, 1, 1, 0, 8'h02);
    rd_chk(1, 1, "R5 leave", 8'hFF);
    // R6: 0x87 mid-sequence restarts the quad key
    cyc(1, 0, 1, 0, 8'h87); cyc(1, 0, 1, 0, 8'h01);
    key_b(8'h87, 8'h01, 8'h55, 8'hAA);
    cyc(1, 0, 1, 0, 8'h21);
    rd_chk(1, 1, "R6 restart", 8'h2A);

    // R1: reset relocks both
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk(0, 1, "R1 relock", 8'hFF);
    rd_chk(1, 1, "R1 relock", 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule